// File: doc/BRIEF.md
# Arcade Credit and Game-State Controller

This block keeps track of whether a coin-operated video game holds a paid credit and whether the machine is playing or showing its attract loop. A debounced coin pulse grants a credit and starts a coin-counter drive pulse. A credit buys one play, or two when the two-plays option is strapped on. Releasing the start button begins a game when a credit is present, the machine is in attract mode and no consumption pulse is running. The game logic raises an end request to return the machine to attract mode. During play it may also ask for the inverted (extended-play) image.

Each drop from play back to attract counts one play as used. A non-retriggerable cycle-count pulse marks the first used play. When that pulse expires in two-play mode, it arms a second used-play flag, so the two flags form a short counter chain. In one-play mode the second flag is treated as set all the time. As soon as the pulse and the second flag are both active, the credit is withdrawn. Without a credit, the game and inverted-display flags are held at zero. All state is in one clock domain with a synchronous active-low reset.

Top module: `credit_state_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, credit_o, game_o, invert_o and coin_cnt_o are all 0 after that edge.
- R2: A 0-to-1 change of coin_i seen at a clock edge sets credit_o after that edge; holding coin_i high for further cycles grants nothing more.
- R3: Each accepted coin edge drives coin_cnt_o high for exactly COUNT_CYC cycles, starting after the edge that accepted the coin.
- R4: A game starts (game_o goes to 1 after the edge) when start_i is seen 1 and then 0 on consecutive edges, credit_o is 1 and game_o is 0; pressing start_i without releasing it starts nothing.
- R5: A start release is ignored while credit_o is 0, while game_o is 1, and while a consumption pulse of PULSE_CYC cycles is running.
- R6: game_end_i high at an edge while game_o is 1 returns game_o to 0 after that edge; in attract mode it has no effect.
- R7: invert_req_i high during play sets invert_o after the edge; invert_o clears at game end and is never set in attract mode.
- R8: With two_play_i at 0, credit_o falls one cycle after game_o falls.
- R9: With two_play_i at 1, the first game end keeps the credit; a second game end that comes after the PULSE_CYC-cycle pulse has expired clears credit_o one cycle after game_o falls.
- R10: Whenever credit_o is 0, game_o and invert_o are 0.
- R11: A coin accepted while credit_o is already 1 discards every used play, so the full number of plays is available again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coin_i | input | 1 | Debounced coin switch level |
| start_i | input | 1 | Start button, 1 while pressed |
| game_end_i | input | 1 | Request from game logic to return to attract mode |
| invert_req_i | input | 1 | Request for the inverted extended-play image |
| two_play_i | input | 1 | 1 = two plays per coin, 0 = one play |
| credit_o | output | 1 | Credit present |
| game_o | output | 1 | 1 = play, 0 = attract |
| invert_o | output | 1 | Inverted image selected |
| coin_cnt_o | output | 1 | Coin-counter drive pulse |

## Verification
Directed runs cover four cases. In one-play mode, a single game ends the credit. In two-play mode, the credit survives the first end. A start attempt during the consumption pulse is blocked, and a second coin is inserted midway through a paid credit. These separate the chain ordering from a plain play counter and the refill behaviour from simple credit setting. Held coin and start levels show the difference between edge and level detection. Start, end and invert requests sent in attract mode and without a credit show that gating is present. A long random phase then mixes coins, button toggles, end and invert requests and flips of the two-play strap against a bench model computed from the requirements.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
   // which transition an edge detector reports
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   // counter width able to hold the value n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/ccs_edge.sv
module ccs_edge
   import ccs_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign pulse_o = level_i & ~prev_q;
      end else begin : g_fall
         assign pulse_o = ~level_i & prev_q;
      end
   endgenerate

   // a detected edge never lasts two cycles (R2, R4)
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/ccs_oneshot.sv
module ccs_oneshot
   import ccs_pkg::*;
#(
   parameter int unsigned LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic trig_i,
   output logic active_o,
   output logic last_o
);
   localparam int unsigned CW = cnt_width(LEN);
   localparam logic [CW-1:0] LOAD = CW'(LEN);

   generate
      if (LEN < 2) begin : g_len_check
         $error("ccs_oneshot: LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   // non-retriggerable: a trigger while running is dropped
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i)   cnt_q <= '0;
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
      else if (trig_i)       cnt_q <= LOAD;
   end

   assign active_o = (cnt_q != '0);
   assign last_o   = (cnt_q == CW'(1));

   // a started pulse spans more than one cycle unless cleared (R3, R9)
   p_pulse_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(active_o) && !clr_i) |=> active_o);
   // a trigger on an idle counter starts a pulse (R9)
   p_trigger_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && trig_i && !clr_i) |=> active_o);
endmodule

// File: rtl/credit_state_ctrl.sv
module credit_state_ctrl
   import ccs_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 12500,
   parameter int unsigned COUNT_CYC = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic coin_i,
   input  logic start_i,
   input  logic game_end_i,
   input  logic invert_req_i,
   input  logic two_play_i,
   output logic credit_o,
   output logic game_o,
   output logic invert_o,
   output logic coin_cnt_o
);
   generate
      if (PULSE_CYC < 2 || COUNT_CYC < 2) begin : g_param_check
         $error("credit_state_ctrl: pulse lengths must be at least 2");
      end
   endgenerate

   logic credit_q, game_q, inv_q, used2_q;
   logic coin_rise, start_rel, leave_game, play_clr;
   logic used1, pulse_last, used2_eff, plays_done, start_ok, cc_last;

   ccs_edge #(.KIND(EDGE_RISE)) u_coin_edge (
      .clk(clk), .rst_n(rst_n), .level_i(coin_i), .pulse_o(coin_rise));

   ccs_edge #(.KIND(EDGE_FALL)) u_start_edge (
      .clk(clk), .rst_n(rst_n), .level_i(start_i), .pulse_o(start_rel));

   assign leave_game = game_q & game_end_i;
   assign play_clr   = ~credit_q | coin_rise;

   // first used play: cycle-count pulse started by a return to attract
   ccs_oneshot #(.LEN(PULSE_CYC)) u_play_used (
      .clk(clk), .rst_n(rst_n), .clr_i(play_clr), .trig_i(leave_game),
      .active_o(used1), .last_o(pulse_last));

   // coin counter drive
   ccs_oneshot #(.LEN(COUNT_CYC)) u_coin_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .trig_i(coin_rise),
      .active_o(coin_cnt_o), .last_o(cc_last));

   // second used play, armed when the first pulse expires
   always_ff @(posedge clk) begin
      if (!rst_n || play_clr) used2_q <= 1'b0;
      else if (pulse_last)    used2_q <= 1'b1;
   end

   assign used2_eff  = used2_q | ~two_play_i;
   assign plays_done = used1 & used2_eff;
   assign start_ok   = start_rel & credit_q & ~game_q & ~used1;

   always_ff @(posedge clk) begin
      if (!rst_n) credit_q <= 1'b0;
      else        credit_q <= coin_rise | (credit_q & ~plays_done);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !credit_q) game_q <= 1'b0;
      else if (leave_game)     game_q <= 1'b0;
      else if (start_ok)       game_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !credit_q || leave_game) inv_q <= 1'b0;
      else if (game_q && invert_req_i)       inv_q <= 1'b1;
   end

   assign credit_o = credit_q;
   assign game_o   = game_q;
   assign invert_o = inv_q;

   p_no_play_without_credit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !credit_o |-> (!game_o && !invert_o));
   p_start_needs_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!credit_o && !game_o) |=> !game_o);
   p_end_leaves_game_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (game_o && game_end_i) |=> (!game_o && !invert_o));
   p_clear_after_use_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (used1 && used2_eff && !coin_rise) |=> !credit_o);
   p_second_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_last && !play_clr) |=> used2_q);
   p_counter_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cc_last |=> !coin_cnt_o);
endmodule

// File: tb/sim_credit_state_ctrl.sv
module sim_credit_state_ctrl;
   localparam int unsigned PULSE = 8;
   localparam int unsigned COUNT = 5;

   logic clk = 1'b0;
   logic rst_n, coin_i, start_i, game_end_i, invert_req_i, two_play_i;
   logic credit_o, game_o, invert_o, coin_cnt_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   credit_state_ctrl #(.PULSE_CYC(PULSE), .COUNT_CYC(COUNT)) u0 (
      .clk(clk), .rst_n(rst_n), .coin_i(coin_i), .start_i(start_i),
      .game_end_i(game_end_i), .invert_req_i(invert_req_i),
      .two_play_i(two_play_i), .credit_o(credit_o), .game_o(game_o),
      .invert_o(invert_o), .coin_cnt_o(coin_cnt_o));

   // reference model built from the requirements
   bit m_live = 1'b0;
   bit m_credit, m_game, m_inv, m_used2, m_coin_q, m_start_q;
   int unsigned m_pcnt, m_ccnt;

   function automatic bit f_next_game(bit cr, bit gm, bit leave, bit ok);
      if (!cr)   return 1'b0;
      if (leave) return 1'b0;
      if (ok)    return 1'b1;
      return gm;
   endfunction

   function automatic bit f_next_inv(bit cr, bit gm, bit inv, bit leave, bit req);
      if (!cr || leave) return 1'b0;
      if (gm && req)    return 1'b1;
      return inv;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_credit = 0; m_game = 0; m_inv = 0; m_used2 = 0;
         m_coin_q = 0; m_start_q = 0; m_pcnt = 0; m_ccnt = 0;
         m_live = 1'b1;
      end else begin
         bit c_rise, s_rel, clr, leave, done, ok;
         bit n_credit, n_game, n_inv, n_used2;
         int unsigned n_pcnt, n_ccnt;
         c_rise = coin_i && !m_coin_q;
         s_rel  = m_start_q && !start_i;
         clr    = !m_credit || c_rise;
         leave  = m_game && game_end_i;
         done   = (m_pcnt != 0) && (m_used2 || !two_play_i);
         ok     = s_rel && m_credit && !m_game && (m_pcnt == 0);
         n_used2  = clr ? 1'b0 : ((m_pcnt == 1) ? 1'b1 : m_used2);
         n_pcnt   = clr ? 0 : ((m_pcnt != 0) ? m_pcnt - 1 : (leave ? PULSE : 0));
         n_ccnt   = (m_ccnt != 0) ? m_ccnt - 1 : (c_rise ? COUNT : 0);
         n_credit = c_rise || (m_credit && !done);
         n_game   = f_next_game(m_credit, m_game, leave, ok);
         n_inv    = f_next_inv(m_credit, m_game, m_inv, leave, invert_req_i);
         m_credit = n_credit; m_game = n_game; m_inv = n_inv;
         m_used2 = n_used2; m_pcnt = n_pcnt; m_ccnt = n_ccnt;
         m_coin_q = coin_i; m_start_q = start_i;
      end
   end

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (m_live) begin
         check(credit_o,   m_credit,      "R2 R8 R9 R11 model credit");
         check(game_o,     m_game,        "R4 R5 R6 model game");
         check(invert_o,   m_inv,         "R7 R10 model invert");
         check(coin_cnt_o, m_ccnt != 0,   "R3 model coin counter");
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic coin_pulse();
      coin_i = 1'b1; tick();
      coin_i = 1'b0; tick();
   endtask

   task automatic press_release();
      start_i = 1'b1; tick();
      start_i = 1'b0; tick();
   endtask

   task automatic end_game();
      game_end_i = 1'b1; tick();
      game_end_i = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; coin_i = 0; start_i = 0; game_end_i = 0;
      invert_req_i = 0; two_play_i = 0;
      @(negedge clk);
      repeat (3) tick();
      check(credit_o, 1'b0, "R1 reset credit");
      check(game_o, 1'b0, "R1 reset game");
      check(invert_o, 1'b0, "R1 reset invert");
      check(coin_cnt_o, 1'b0, "R1 reset counter");
      rst_n = 1'b1;
      tick();

      // one play per coin
      coin_i = 1'b1; tick();
      check(credit_o, 1'b1, "R2 coin grants credit");
      check(coin_cnt_o, 1'b1, "R3 counter starts");
      tick(); tick();
      coin_i = 1'b0;
      tick(); tick();
      check(coin_cnt_o, 1'b1, "R3 counter last cycle");
      tick();
      check(coin_cnt_o, 1'b0, "R3 counter single pulse for held coin");
      start_i = 1'b1; tick(); tick();
      check(game_o, 1'b0, "R4 press alone starts nothing");
      start_i = 1'b0; tick();
      check(game_o, 1'b1, "R4 release starts game");
      invert_req_i = 1'b1; tick(); invert_req_i = 1'b0;
      check(invert_o, 1'b1, "R7 invert in play");
      press_release();
      check(game_o, 1'b1, "R5 start ignored in play");
      end_game();
      check(game_o, 1'b0, "R6 end returns to attract");
      check(invert_o, 1'b0, "R7 invert cleared at end");
      check(credit_o, 1'b1, "R8 credit one cycle after end");
      tick();
      check(credit_o, 1'b0, "R8 credit cleared in one-play mode");
      press_release();
      check(game_o, 1'b0, "R5 start ignored without credit");
      invert_req_i = 1'b1; tick(); invert_req_i = 1'b0;
      check(invert_o, 1'b0, "R7 invert ignored in attract");
      check(game_o, 1'b0, "R10 no play without credit");
      end_game();
      check(game_o, 1'b0, "R6 end ignored in attract");

      // two plays per coin
      two_play_i = 1'b1;
      coin_pulse();
      press_release();
      check(game_o, 1'b1, "R9 first game starts");
      end_game();
      check(credit_o, 1'b1, "R9 credit kept after first end");
      press_release();
      check(game_o, 1'b0, "R5 start blocked during pulse");
      repeat (PULSE + 2) tick();
      check(credit_o, 1'b1, "R9 credit kept after pulse");
      press_release();
      check(game_o, 1'b1, "R9 second game starts");
      end_game();
      check(credit_o, 1'b1, "R9 credit one cycle after second end");
      tick();
      check(credit_o, 1'b0, "R9 credit cleared after second play");

      // refill while a credit is present
      coin_pulse();
      press_release(); end_game();
      repeat (PULSE + 2) tick();
      coin_pulse();
      press_release(); end_game();
      repeat (PULSE + 2) tick();
      check(credit_o, 1'b1, "R11 refill keeps credit after one more game");
      press_release(); end_game();
      tick();
      check(credit_o, 1'b0, "R11 refill ends after two plays");

      // random phase, compared against the model every cycle
      for (int i = 0; i < 3000; i++) begin
         coin_i       = ($urandom % 40) == 0;
         if (($urandom % 5) == 0) start_i = ~start_i;
         game_end_i   = ($urandom % 20) == 0;
         invert_req_i = ($urandom % 20) == 0;
         if (($urandom % 100) == 0) two_play_i = ~two_play_i;
         tick();
      end
      summary();
      $finish;
   end
endmodule